// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block produces memory addresses for a processing datapath using post-modify indexing. It stores four index pointers, four modify values and four buffer lengths, all 16 bits wide. An access names one pointer and one modify value. In that same cycle the block emits the low 14 bits of the named pointer as the address. On the clock edge that closes the access it adds the modify value to the pointer.

A nonzero length turns a pointer into a circular-buffer cursor. The buffer base is the pointer aligned down to the smallest power of two that is at least the length. The updated pointer is folded back into the range base to base+length-1. A zero length gives plain 16-bit two's-complement stepping. A bit-reverse control mirrors the emitted address, which serves FFT-style reordering. The control leaves the stored pointer untouched.

Accesses are always accepted. There is no back-pressure: `addr_valid` follows `acc_valid` in the same cycle, and a consumer must take the address in that cycle. Register reads are combinational. A register write lands on the next clock edge.

Top module: `dag_mod`

## Requirements
- R1: After reset, every index, modify and length register reads 0.
- R2: A write with `wr_grp` 0 (index), 1 (modify) or 2 (length) and `wr_idx` k stores `wr_data` into register k of that group at the clock edge. `rd_data` returns the register named by `rd_grp`/`rd_idx` combinationally. A write with group 3 changes no register, and a read with group 3 returns 0.
- R3: While `acc_valid` is high, `addr` equals bits 13:0 of index register `acc_isel` in the same cycle, and `addr_valid` equals `acc_valid`.
- R4: With the selected pointer's length at 0, an access leaves the pointer at pointer + modify register `acc_msel`, modulo 2^16.
- R5: With a nonzero length L and a modify magnitude below L, an access leaves the pointer at base + ((offset + modify) folded into 0..L-1). Here base is the pointer with its low bits cleared up to the smallest power of two at least L, and offset is the pointer minus base.
- R6: In a cycle with no access and no index write, no index register changes.
- R7: With `brev_en` high, `addr` bit k equals pointer bit 13-k. The stored pointer still updates exactly as without reversal.
- R8: An index write to the same pointer that an access names in the same cycle wins: the pointer takes `wr_data`, not the post-modified value.
- R9: An access changes only the pointer named by `acc_isel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_grp | input | 2 | Write group: 0 index, 1 modify, 2 length, 3 none |
| wr_idx | input | 2 | Register number within the group |
| wr_data | input | 16 | Write data |
| rd_grp | input | 2 | Read group, same encoding as the write group |
| rd_idx | input | 2 | Register number to read |
| rd_data | output | 16 | Combinational read data |
| acc_valid | input | 1 | Access strobe |
| acc_isel | input | 2 | Pointer selected for the access |
| acc_msel | input | 2 | Modify register selected for the access |
| brev_en | input | 1 | Emit the address bit-reversed |
| addr_valid | output | 1 | Address is valid this cycle |
| addr | output | 14 | Emitted address |

## Verification
Two functions can fall in the same cycle: a software write to an index register and the post-modify update of that same pointer. The bench provokes this by raising `acc_valid` on pointer 0 while a group-0 write to index 0 is driven on the same clock edge. It then reads the pointer back and expects exactly the written value, not the modified one. A related overlap, bit reversal on an access that also steps the pointer, is judged twice. The emitted address is checked as the mirrored pattern. The stored pointer is checked as the ordinary post-modify result.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int DW    = 16;
  localparam int NREG  = 4;
  localparam int IW    = $clog2(NREG);
  localparam int ABITS = 14;

  typedef enum logic [1:0] {
    GRP_I    = 2'd0,
    GRP_M    = 2'd1,
    GRP_L    = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  // Fill every bit below the highest set bit: gives 2^k-1 covering v.
  function automatic logic [DW-1:0] smear(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    r = v;
    for (int s = 1; s < DW; s = s * 2) r = r | (r >> s);
    return r;
  endfunction
endpackage

// File: rtl/dag_regfile.sv
module dag_regfile
  import dag_pkg::*;
#(
  parameter int N = NREG,
  parameter int W = DW,
  localparam int XW = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_grp,
  input  logic [XW-1:0]      wr_idx,
  input  logic [W-1:0]       wr_data,
  input  logic               upd_en,
  input  logic [XW-1:0]      upd_idx,
  input  logic [W-1:0]       upd_val,
  output logic [N-1:0][W-1:0] i_q,
  output logic [N-1:0][W-1:0] m_q,
  output logic [N-1:0][W-1:0] l_q
);
  grp_e grp;
  assign grp = grp_e'(wr_grp);

  for (genvar k = 0; k < N; k++) begin : g_reg
    logic hit_i, hit_m, hit_l;
    assign hit_i = wr_en && (grp == GRP_I) && (wr_idx == XW'(k));
    assign hit_m = wr_en && (grp == GRP_M) && (wr_idx == XW'(k));
    assign hit_l = wr_en && (grp == GRP_L) && (wr_idx == XW'(k));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        i_q[k] <= '0;
        m_q[k] <= '0;
        l_q[k] <= '0;
      end else begin
        if (hit_i)                              i_q[k] <= wr_data;
        else if (upd_en && upd_idx == XW'(k))   i_q[k] <= upd_val;
        if (hit_m) m_q[k] <= wr_data;
        if (hit_l) l_q[k] <= wr_data;
      end
    end
  end

  // R6
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && grp == GRP_I) && !upd_en) |=> $stable(i_q));

  // R8
  wr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && grp == GRP_I && upd_en && upd_idx == wr_idx)
      |=> (i_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/dag_modulo.sv
module dag_modulo
  import dag_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chk_en,
  input  logic [W-1:0] ptr,
  input  logic [W-1:0] mod,
  input  logic [W-1:0] len,
  output logic [W-1:0] nxt
);
  logic [W-1:0] mask, base, mag;
  logic [W:0]   off, sum, fold;

  assign mask = smear(len - W'(1));
  assign base = ptr & ~mask;
  assign off  = {1'b0, ptr & mask};
  assign sum  = off + {mod[W-1], mod};
  assign mag  = mod[W-1] ? (~mod + W'(1)) : mod;

  always_comb begin
    fold = sum;
    if (!mod[W-1]) begin
      if (sum >= {1'b0, len}) fold = sum - {1'b0, len};
    end else if (sum[W]) begin
      fold = sum + {1'b0, len};
    end
    if (len == '0) nxt = ptr + mod;
    else           nxt = base + fold[W-1:0];
  end

  // R5
  wrap_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && len != '0 && mag < len)
      |-> (((nxt & ~mask) == base) && ((nxt & mask) < len)));
endmodule

// File: rtl/dag_bitrev.sv
module dag_bitrev #(
  parameter int A = 14,
  parameter bit ENABLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rev,
  input  logic [A-1:0] a_in,
  output logic [A-1:0] a_out
);
  logic [A-1:0] mirrored;

  for (genvar k = 0; k < A; k++) begin : g_bit
    assign mirrored[k] = a_in[A-1-k];
  end

  if (ENABLE) begin : g_on
    assign a_out = rev ? mirrored : a_in;
  end else begin : g_off
    assign a_out = a_in;
  end

  // R7
  rev_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(a_out) == $countones(a_in));
endmodule

// File: rtl/dag_mod.sv
module dag_mod
  import dag_pkg::*;
#(
  parameter bit BITREV_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_grp,
  input  logic [IW-1:0]    wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [1:0]       rd_grp,
  input  logic [IW-1:0]    rd_idx,
  output logic [DW-1:0]    rd_data,
  input  logic             acc_valid,
  input  logic [IW-1:0]    acc_isel,
  input  logic [IW-1:0]    acc_msel,
  input  logic             brev_en,
  output logic             addr_valid,
  output logic [ABITS-1:0] addr
);
  logic [NREG-1:0][DW-1:0] i_q, m_q, l_q;
  logic [DW-1:0] cur_i, cur_m, cur_l, nxt_i;

  assign cur_i = i_q[acc_isel];
  assign cur_m = m_q[acc_msel];
  assign cur_l = l_q[acc_isel];

  dag_regfile #(.N(NREG), .W(DW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_grp(wr_grp), .wr_idx(wr_idx), .wr_data(wr_data),
    .upd_en(acc_valid), .upd_idx(acc_isel), .upd_val(nxt_i),
    .i_q(i_q), .m_q(m_q), .l_q(l_q)
  );

  dag_modulo #(.W(DW)) u_mod (
    .clk(clk), .rst_n(rst_n), .chk_en(acc_valid),
    .ptr(cur_i), .mod(cur_m), .len(cur_l), .nxt(nxt_i)
  );

  dag_bitrev #(.A(ABITS), .ENABLE(BITREV_EN)) u_rev (
    .clk(clk), .rst_n(rst_n), .rev(brev_en),
    .a_in(cur_i[ABITS-1:0]), .a_out(addr)
  );

  assign addr_valid = acc_valid;

  always_comb begin
    case (grp_e'(rd_grp))
      GRP_I:   rd_data = i_q[rd_idx];
      GRP_M:   rd_data = m_q[rd_idx];
      GRP_L:   rd_data = l_q[rd_idx];
      default: rd_data = '0;
    endcase
  end

  // R9
  other_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !(wr_en && wr_grp == 2'd0) && acc_isel != 2'd0)
      |=> $stable(i_q[0]));
endmodule

// File: tb/dag_mod_test.sv
module dag_mod_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [1:0] wr_grp = 0, wr_idx = 0; logic [15:0] wr_data = 0;
  logic [1:0] rd_grp = 0, rd_idx = 0; logic [15:0] rd_data;
  logic acc_valid = 0; logic [1:0] acc_isel = 0, acc_msel = 0; logic brev_en = 0;
  logic addr_valid; logic [13:0] addr;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dag_mod uut (.*);

  // {isel, msel, brev, expected addr, expected pointer after}
  localparam logic [34:0] VEC [0:7] = '{
    {2'd0, 2'd0, 1'b0, 14'h0010, 16'h0011},  // R4
    {2'd1, 2'd1, 1'b0, 14'h0103, 16'h0101},  // R5 upward fold
    {2'd1, 2'd1, 1'b0, 14'h0101, 16'h0104},  // R5
    {2'd2, 2'd2, 1'b0, 14'h0002, 16'h0005},  // R5 downward fold
    {2'd2, 2'd2, 1'b0, 14'h0005, 16'h0002},  // R5
    {2'd3, 2'd3, 1'b1, 14'h0B12, 16'h1236},  // R7
    {2'd0, 2'd3, 1'b0, 14'h0011, 16'h0013},  // R4
    {2'd3, 2'd2, 1'b0, 14'h1236, 16'h1233}   // R4 negative step
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] g, input logic [1:0] i, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_grp = g; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] g, input logic [1:0] i, output logic [15:0] d);
    rd_grp = g; rd_idx = i; #1; d = rd_data;
  endtask

  initial begin : watchdog
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int g = 0; g < 3; g++)
      for (int i = 0; i < 4; i++) begin
        rd(g[1:0], i[1:0], v); chk("R1 reset", v, 16'h0);
      end

    wr(0, 0, 16'h0010); wr(1, 0, 16'h0001);
    wr(0, 1, 16'h0103); wr(1, 1, 16'h0003); wr(2, 1, 16'h0005);
    wr(0, 2, 16'h0002); wr(1, 2, 16'hFFFD); wr(2, 2, 16'h0006);
    wr(0, 3, 16'h1234); wr(1, 3, 16'h0002);
    rd(1, 2, v); chk("R2 write-read", v, 16'hFFFD);
    wr(3, 1, 16'hBEEF);
    rd(0, 1, v); chk("R2 grp3 I", v, 16'h0103);
    rd(1, 1, v); chk("R2 grp3 M", v, 16'h0003);
    rd(2, 1, v); chk("R2 grp3 L", v, 16'h0005);
    rd(3, 1, v); chk("R2 grp3 read", v, 16'h0000);

    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      acc_valid = 1; acc_isel = VEC[n][34:33]; acc_msel = VEC[n][32:31];
      brev_en = VEC[n][30];
      #1;
      chk("R3 addr", {2'b0, addr}, {2'b0, VEC[n][29:16]});
      chk("R3 valid", {15'b0, addr_valid}, 16'h1);
      @(negedge clk);
      acc_valid = 0; brev_en = 0;
      rd(0, VEC[n][34:33], v); chk("R4/R5/R7 pointer", v, VEC[n][15:0]);
      if (n == 0) begin
        rd(0, 1, v); chk("R9 other pointer", v, 16'h0103);
      end
    end

    repeat (3) @(negedge clk);
    rd(0, 2, v); chk("R6 idle hold", v, 16'h0002);
    rd(0, 0, v); chk("R6 idle hold", v, 16'h0013);

    wr(0, 0, 16'hFFFF); wr(1, 0, 16'h0001);
    @(negedge clk);
    acc_valid = 1; acc_isel = 0; acc_msel = 0;
    @(negedge clk);
    acc_valid = 0;
    rd(0, 0, v); chk("R4 16-bit wrap", v, 16'h0000);

    @(negedge clk);
    acc_valid = 1; acc_isel = 0; acc_msel = 0;
    wr_en = 1; wr_grp = 0; wr_idx = 0; wr_data = 16'h0777;
    @(negedge clk);
    acc_valid = 0; wr_en = 0;
    rd(0, 0, v); chk("R8 write wins", v, 16'h0777);

    @(negedge clk);
    acc_valid = 0; acc_isel = 1;
    #1; chk("R3 idle valid", {15'b0, addr_valid}, 16'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule